// File: doc/BRIEF.md
# Data-Strobe Credit Transmitter

This block turns link characters into a two-wire data-strobe signal. It runs on a single clock and emits one line bit every `div + 1` clock cycles. Whenever nothing else is waiting it sends NULLs (an escape followed by a flow-control token). On top of that stream it places three kinds of traffic. Time codes are sent when the `tick_in` strobe fires. Flow-control tokens are sent whenever local receive space exceeds what has already been promised to the far end. Host characters (bytes, or end-of-packet markers) are sent while the far end has granted credit.

The host offers a character by holding `wr_valid` together with `wr_flag` and `wr_data`. The transmitter takes the character in the cycle where `wr_ready` is high. The controller beside the transmitter reports two events: each flow token received from the far end arrives as `fct_rcvd`, and each character the local receiver hands onward arrives as `rx_taken`. Lowering `tx_en` stops the link, drops both lines to 0 and clears all credit and promise state.

Top module: `ds_credit_tx`

## Requirements
- R1: While reset is held, `ds_d`, `ds_s`, `wr_ready` and `cred_err` are all 0.
- R2: Each line bit is encoded by changing exactly one of the two lines. `ds_d` carries the bit value, and `ds_s` toggles whenever `ds_d` keeps its previous value. After enable, with both lines at 0, the first change is `ds_s` rising while `ds_d` stays 0.
- R3: Successive line changes are exactly `div + 1` clock cycles apart while enabled.
- R4: After enable, the first character is a NULL: an escape (bits sent P,1,1,1) followed by a flow token (P,1,0,0). NULLs repeat whenever nothing else is pending.
- R5: Each character's first bit P is chosen so that the XOR over the previous character's payload bits, the current character's type bit and P is 1. The payload is the two code bits of a control character or the eight bits of a data character. Before the first character the previous payload is taken as all zero.
- R6: A data character is sent as P, 0, then data bits 0 to 7 in that order. With `wr_flag`=1, a host character is sent as a control character (P,1,c0,c1): end-of-packet (c0=0, c1=1) when `wr_data[0]`=0, error end (c0=1, c1=0) when `wr_data[0]`=1.
- R7: A one-cycle `tick_in` pulse causes an escape followed by a data character whose byte is {`ctrl_in`, `time_in`}, with `ctrl_in` in bits 7:6, captured at the pulse.
- R8: Each `fct_rcvd` pulse adds 8 to the transmit credit, and each accepted host character removes 1. `wr_ready` is high for exactly one cycle per accepted character and only while credit is nonzero. With a single grant, the ninth character is not accepted until a further grant arrives.
- R9: A flow token is sent when `fct_en` is high and `rx_room` is at least the outstanding promise plus 8. Each flow token sent adds 8 to the promise, and each `rx_taken` pulse removes 1 from it.
- R10: At a character boundary the pending traffic is served in this order: time code, then flow token, then host character, then NULL. The second half of a NULL or time code always follows its escape directly.
- R11: A grant that would lift the credit above 56 pulses `cred_err` high for one cycle, the cycle after the grant, and leaves the credit unchanged.
- R12: With `tx_en` low, both lines reach 0 within two bit periods and then stay still. Credit and promise restart from zero when the link is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Link enable; low holds the line quiet and clears state |
| div | input | 8 | Bit period minus one, in clock cycles |
| fct_en | input | 1 | Flow tokens may be sent |
| rx_room | input | 6 | Free space in the local receive buffer |
| rx_taken | input | 1 | One received character left the local buffer |
| fct_rcvd | input | 1 | One flow token arrived from the far end |
| tick_in | input | 1 | Request to send a time code |
| ctrl_in | input | 2 | Control bits of the time code |
| time_in | input | 6 | Time value of the time code |
| wr_valid | input | 1 | Host offers a character |
| wr_flag | input | 1 | 1 marks a packet end marker, 0 a data byte |
| wr_data | input | 8 | Host byte; bit 0 selects the end marker kind |
| wr_ready | output | 1 | Host character accepted this cycle |
| cred_err | output | 1 | One-cycle pulse on credit overflow |
| ds_d | output | 1 | Data line |
| ds_s | output | 1 | Strobe line |

## Verification
The bench decodes the two lines back into characters and checks every parity bit against the rule chained across characters. A parity chain restarted per character, or one that ignored the type bit, shows up as a parity miss on the first data character that follows a control character. It drives a ninth host character on a single grant: a credit counter that checks too late acknowledges it, and one that loses the grant-plus-take case in the same cycle drifts by one. Time code, flow token and host byte are made pending together, so a wrong priority order appears as tokens out of sequence. A grant past 56 checks both the one error pulse and that exactly 56 characters still pass afterwards, which catches a counter that wraps or saturates at the wrong value.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

   localparam int BYTE_W = 8;

   // control codes as {c1, c0}; c0 goes out first
   localparam logic [1:0] CODE_FCT = 2'b00;
   localparam logic [1:0] CODE_ESC = 2'b11;
   localparam logic [1:0] CODE_EOP = 2'b10;
   localparam logic [1:0] CODE_EEP = 2'b01;

   typedef enum logic [2:0] {
      SEL_NULL,
      SEL_NULLFCT,
      SEL_TCESC,
      SEL_TCDATA,
      SEL_FCT,
      SEL_HOST
   } sel_e;

   typedef enum logic [1:0] {
      FU_NONE,
      FU_FCT,
      FU_TIME
   } follow_e;

   // bits[0] is sent first
   typedef struct packed {
      logic [9:0] bits;
      logic       is_data;
      logic       pay_par;
   } char_t;

   function automatic char_t make_ctrl(input logic [1:0] code, input logic prev_par);
      char_t c;
      c.bits    = {6'b0, code[1], code[0], 1'b1, prev_par};
      c.is_data = 1'b0;
      c.pay_par = code[0] ^ code[1];
      return c;
   endfunction

   function automatic char_t make_data(input logic [BYTE_W-1:0] b, input logic prev_par);
      char_t c;
      c.bits    = {b, 1'b0, ~prev_par};
      c.is_data = 1'b1;
      c.pay_par = ^b;
      return c;
   endfunction

endpackage

// File: rtl/ds_tx_bitclk.sv
module ds_tx_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("ds_tx_bitclk: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (cnt == '0)
         cnt <= div;
      else
         cnt <= cnt - 1'b1;
   end

   assign tick = (cnt == '0);

   // R3
   bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0) |=> !tick);

endmodule

// File: rtl/ds_tx_credit.sv
module ds_tx_credit #(
   parameter int ROOM_W   = 6,
   parameter int GRANT    = 8,
   parameter int CRED_MAX = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fct_rcvd,
   input  logic              take,
   input  logic              fct_sent,
   input  logic              rx_taken,
   input  logic              fct_en,
   input  logic [ROOM_W-1:0] rx_room,
   output logic              has_credit,
   output logic              fct_due,
   output logic              cred_err
);

   localparam int CRED_W = $clog2(CRED_MAX + 1);
   localparam int SUM_W  = CRED_W + 1;
   localparam int PROM_W = ROOM_W + 1;
   localparam int CMP_W  = ROOM_W + 2;

   generate
      if (GRANT < 1 || CRED_MAX < GRANT) begin : g_bad_grant
         $error("ds_tx_credit: need 1 <= GRANT <= CRED_MAX");
      end
      if (ROOM_W < 1) begin : g_bad_room
         $error("ds_tx_credit: ROOM_W must be at least 1");
      end
   endgenerate

   logic [CRED_W-1:0] credit, credit_nx;
   logic [SUM_W-1:0]  granted;
   logic              over;
   logic [PROM_W-1:0] promised, promised_nx;

   always_comb begin
      granted   = {1'b0, credit} + (fct_rcvd ? SUM_W'(GRANT) : '0);
      over      = fct_rcvd && (granted > SUM_W'(CRED_MAX));
      credit_nx = over ? credit - CRED_W'(take)
                       : granted[CRED_W-1:0] - CRED_W'(take);
      promised_nx = promised + (fct_sent ? PROM_W'(GRANT) : '0)
                             - PROM_W'(rx_taken && promised != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         credit   <= '0;
         promised <= '0;
         cred_err <= 1'b0;
      end else if (clr) begin
         credit   <= '0;
         promised <= '0;
         cred_err <= 1'b0;
      end else begin
         credit   <= credit_nx;
         promised <= promised_nx;
         cred_err <= over;
      end
   end

   assign has_credit = (credit != '0);
   assign fct_due    = fct_en &&
                       (CMP_W'(rx_room) >= CMP_W'(promised) + CMP_W'(GRANT));

   // R11
   credit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      credit <= CRED_W'(CRED_MAX));

   // R8
   take_needs_credit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> credit != '0);

   // R8
   grant_adds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && fct_rcvd && !take && credit == '0) |=> credit == CRED_W'(GRANT));

   // R11
   over_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && fct_rcvd && !take && credit == CRED_W'(CRED_MAX))
      |=> (cred_err && credit == CRED_W'(CRED_MAX)));

   // R9
   fct_promise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fct_sent |-> fct_due);

endmodule

// File: rtl/ds_tx_line.sv
module ds_tx_line (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic run,
   input  logic bit_in,
   output logic ds_d,
   output logic ds_s
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ds_d <= 1'b0;
         ds_s <= 1'b0;
      end else if (tick) begin
         if (run) begin
            ds_d <= bit_in;
            ds_s <= ds_s ^ (bit_in ~^ ds_d);
         end else if (ds_d) begin
            ds_d <= 1'b0;
         end else begin
            ds_s <= 1'b0;
         end
      end
   end

   // R2
   one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && run) |=> ($countones({ds_d ^ $past(ds_d), ds_s ^ $past(ds_s)}) == 1));

   // R3
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(ds_d) && $stable(ds_s)));

   // R12
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ds_d && !ds_s) |=> (!ds_d && !ds_s));

endmodule

// File: rtl/ds_credit_tx.sv
module ds_credit_tx
   import ds_tx_pkg::*;
#(
   parameter int DIV_W    = 8,
   parameter int ROOM_W   = 6,
   parameter int GRANT    = 8,
   parameter int CRED_MAX = 56
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [DIV_W-1:0]  div,
   input  logic              fct_en,
   input  logic [ROOM_W-1:0] rx_room,
   input  logic              rx_taken,
   input  logic              fct_rcvd,
   input  logic              tick_in,
   input  logic [1:0]        ctrl_in,
   input  logic [5:0]        time_in,
   input  logic              wr_valid,
   input  logic              wr_flag,
   input  logic [7:0]        wr_data,
   output logic              wr_ready,
   output logic              cred_err,
   output logic              ds_d,
   output logic              ds_s
);

   localparam int LEFT_W    = 4;
   localparam int CTRL_LAST = 3;
   localparam int DATA_LAST = 9;

   logic              tick;
   logic              boundary;
   logic [8:0]        sh;
   logic [LEFT_W-1:0] left;
   logic              prev_par;
   logic              sent_any;
   follow_e           follow;
   logic              tc_pend;
   logic [7:0]        tc_byte;
   logic              has_credit, fct_due;
   sel_e              sel;
   char_t             nc;
   logic              take, fct_sent, bit_out;

   ds_tx_bitclk #(.DIV_W(DIV_W)) u_bitclk (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (div),
      .tick (tick)
   );

   assign boundary = tick && tx_en && (left == '0);

   // service order at a character boundary
   always_comb begin
      if (follow == FU_FCT)       sel = SEL_NULLFCT;
      else if (follow == FU_TIME) sel = SEL_TCDATA;
      else if (!sent_any)         sel = SEL_NULL;
      else if (tc_pend)           sel = SEL_TCESC;
      else if (fct_due)           sel = SEL_FCT;
      else if (wr_valid && has_credit) sel = SEL_HOST;
      else                        sel = SEL_NULL;

      case (sel)
         SEL_NULLFCT, SEL_FCT: nc = make_ctrl(CODE_FCT, prev_par);
         SEL_TCDATA:           nc = make_data(tc_byte, prev_par);
         SEL_HOST:             nc = wr_flag ? make_ctrl(wr_data[0] ? CODE_EEP : CODE_EOP, prev_par)
                                            : make_data(wr_data, prev_par);
         default:              nc = make_ctrl(CODE_ESC, prev_par);
      endcase
   end

   assign take     = boundary && (sel == SEL_HOST);
   assign fct_sent = boundary && (sel == SEL_FCT);
   assign wr_ready = take;
   assign bit_out  = boundary ? nc.bits[0] : sh[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh       <= '0;
         left     <= '0;
         prev_par <= 1'b0;
         sent_any <= 1'b0;
         follow   <= FU_NONE;
         tc_pend  <= 1'b0;
         tc_byte  <= '0;
      end else if (!tx_en) begin
         sh       <= '0;
         left     <= '0;
         prev_par <= 1'b0;
         sent_any <= 1'b0;
         follow   <= FU_NONE;
         tc_pend  <= 1'b0;
      end else begin
         if (boundary) begin
            sh       <= nc.bits[9:1];
            left     <= nc.is_data ? LEFT_W'(DATA_LAST) : LEFT_W'(CTRL_LAST);
            prev_par <= nc.pay_par;
            sent_any <= 1'b1;
            if (sel == SEL_NULL)       follow <= FU_FCT;
            else if (sel == SEL_TCESC) follow <= FU_TIME;
            else                       follow <= FU_NONE;
            if (sel == SEL_TCESC) tc_pend <= 1'b0;
         end else if (tick && left != '0) begin
            sh   <= sh >> 1;
            left <= left - 1'b1;
         end
         if (tick_in) begin
            tc_pend <= 1'b1;
            tc_byte <= {ctrl_in, time_in};
         end
      end
   end

   ds_tx_credit #(
      .ROOM_W  (ROOM_W),
      .GRANT   (GRANT),
      .CRED_MAX(CRED_MAX)
   ) u_credit (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!tx_en),
      .fct_rcvd  (fct_rcvd),
      .take      (take),
      .fct_sent  (fct_sent),
      .rx_taken  (rx_taken),
      .fct_en    (fct_en),
      .rx_room   (rx_room),
      .has_credit(has_credit),
      .fct_due   (fct_due),
      .cred_err  (cred_err)
   );

   ds_tx_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .run   (tx_en),
      .bit_in(bit_out),
      .ds_d  (ds_d),
      .ds_s  (ds_s)
   );

   // R8
   ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ready |-> wr_valid);

   // R10
   time_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && follow == FU_NONE && sent_any && tc_pend) |-> (!wr_ready && !fct_sent));

   // R4
   first_null_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !sent_any) |=> (follow == FU_FCT));

endmodule

// File: tb/ds_credit_tx_test.sv
`timescale 1ns/1ps
module ds_credit_tx_test;

   localparam int K_NULL = 0, K_FCT = 1, K_DATA = 2, K_EOP = 3,
                  K_EEP = 4, K_TIME = 5, K_BAD = 6, K_ESC = 7;

   // {flag, data[7:0], kind[3:0], val[7:0]}
   localparam logic [20:0] VEC [0:8] = '{
      {1'b0, 8'hA5, 4'd2, 8'hA5},
      {1'b0, 8'h3C, 4'd2, 8'h3C},
      {1'b1, 8'h00, 4'd3, 8'h00},
      {1'b0, 8'hFF, 4'd2, 8'hFF},
      {1'b1, 8'h01, 4'd4, 8'h00},
      {1'b0, 8'h00, 4'd2, 8'h00},
      {1'b1, 8'hFE, 4'd3, 8'h00},
      {1'b0, 8'h81, 4'd2, 8'h81},
      {1'b0, 8'h42, 4'd2, 8'h42}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_en = 1'b0;
   logic [7:0] div = 8'd1;
   logic       fct_en = 1'b0;
   logic [5:0] rx_room = '0;
   logic       rx_taken = 1'b0;
   logic       fct_rcvd = 1'b0;
   logic       tick_in = 1'b0;
   logic [1:0] ctrl_in = '0;
   logic [5:0] time_in = '0;
   logic       wr_valid = 1'b0;
   logic       wr_flag = 1'b0;
   logic [7:0] wr_data = '0;
   logic       wr_ready, cred_err, ds_d, ds_s;

   always #2.5 clk = ~clk;

   ds_credit_tx uut (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div(div), .fct_en(fct_en),
      .rx_room(rx_room), .rx_taken(rx_taken), .fct_rcvd(fct_rcvd),
      .tick_in(tick_in), .ctrl_in(ctrl_in), .time_in(time_in),
      .wr_valid(wr_valid), .wr_flag(wr_flag), .wr_data(wr_data),
      .wr_ready(wr_ready), .cred_err(cred_err), .ds_d(ds_d), .ds_s(ds_s)
   );

   int total = 0, bad = 0;
   int cyc = 0, ack_cnt = 0, err_cnt = 0, chg_cnt = 0;
   int enc_bad = 0, per_bad = 0, par_bad = 0;
   int last_chg = 0;
   bit have_last = 0, arm = 0, parse_on = 0, fc_seen = 0, finished = 0;
   logic fc_d = 0, fc_s = 0, pd = 0, ps = 0;
   logic [9:0] pbuf = '0;
   int pcnt = 0;
   logic ppar = 0, esc_pend = 0;
   int first_kind = -1, null_cnt = 0, n_tok = 0;
   int tok_k [0:255];
   int tok_v [0:255];

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_eq(input string req, input int act, input int exp);
      check(act == exp, req, act, exp);
   endtask

   task automatic log_tok(input int k, input int v);
      if (first_kind < 0) first_kind = k;
      if (n_tok < 256) begin
         tok_k[n_tok] = k;
         tok_v[n_tok] = v;
      end
      n_tok++;
   endtask

   task automatic feed(input logic b);
      int k, v;
      logic fl;
      pbuf[pcnt] = b;
      pcnt++;
      if ((pcnt == 4 && pbuf[1]) || pcnt == 10) begin
         fl = pbuf[1];
         if (pbuf[0] !== ~(ppar ^ fl)) par_bad++;
         v = 0;
         if (fl) begin
            case ({pbuf[3], pbuf[2]})
               2'b00:   k = K_FCT;
               2'b11:   k = K_ESC;
               2'b10:   k = K_EOP;
               default: k = K_EEP;
            endcase
            ppar = pbuf[2] ^ pbuf[3];
         end else begin
            k = K_DATA;
            v = int'(pbuf[9:2]);
            ppar = ^pbuf[9:2];
         end
         if (esc_pend) begin
            esc_pend = 0;
            if (k == K_FCT) begin
               null_cnt++;
               if (first_kind < 0) first_kind = K_NULL;
            end else if (k == K_DATA) log_tok(K_TIME, v);
            else log_tok(K_BAD, 0);
         end else if (k == K_ESC) esc_pend = 1;
         else log_tok(k, v);
         pcnt = 0;
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (wr_ready) ack_cnt++;
      if (cred_err) err_cnt++;
      if (ds_d !== pd || ds_s !== ps) begin
         chg_cnt++;
         if (ds_d !== pd && ds_s !== ps) enc_bad++;
         if (!fc_seen) begin
            fc_seen = 1;
            fc_d = ds_d;
            fc_s = ds_s;
         end
         if (arm) begin
            if (have_last && (cyc - last_chg) != int'(div) + 1) per_bad++;
            have_last = 1;
            last_chg = cyc;
         end
         if (parse_on) feed(ds_d);
         pd = ds_d;
         ps = ds_s;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic enable_link();
      pcnt = 0; ppar = 0; esc_pend = 0; fc_seen = 0; first_kind = -1;
      arm = 0; have_last = 0; parse_on = 1;
      tx_en = 1'b1;
   endtask

   task automatic disable_link();
      tx_en = 1'b0; parse_on = 0; arm = 0;
   endtask

   task automatic write_char(input logic f, input logic [7:0] d, input int maxwait, output bit got);
      wr_valid = 1'b1; wr_flag = f; wr_data = d; got = 0;
      for (int i = 0; i < maxwait; i++) begin
         @(negedge clk);
         if (wr_ready) begin
            got = 1;
            break;
         end
      end
      @(posedge clk);
      #1;
      wr_valid = 1'b0;
   endtask

   task automatic grant();
      fct_rcvd = 1'b1;
      cycles(1);
      fct_rcvd = 1'b0;
      cycles(1);
   endtask

   function automatic int count_kind(input int from, input int k);
      int c = 0;
      for (int i = from; i < n_tok && i < 256; i++) if (tok_k[i] == k) c++;
      return c;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      bit got;
      int base, a0, e0;
      cycles(3);
      @(negedge clk);
      // R1 reset state
      check_eq("R1 ds_d", ds_d, 0);
      check_eq("R1 ds_s", ds_s, 0);
      check_eq("R1 wr_ready", wr_ready, 0);
      check_eq("R1 cred_err", cred_err, 0);
      @(posedge clk); #1;
      rst_n = 1'b1;
      cycles(3);

      // R4, R2: enable, idle NULLs
      enable_link();
      cycles(10);
      arm = 1;
      cycles(190);
      check_eq("R4 first char NULL", first_kind, K_NULL);
      check(null_cnt >= 10, "R4 idle NULL count", null_cnt, 10);
      check_eq("R4 no other tokens", n_tok, 0);
      check_eq("R2 first change d", fc_d, 0);
      check_eq("R2 first change s", fc_s, 1);

      // R8 zero credit blocks host
      write_char(1'b0, 8'h55, 100, got);
      check_eq("R8 no ack without credit", got, 0);
      check_eq("R8 nothing sent without credit", n_tok, 0);

      // R8, R6: table of host characters on one grant
      base = n_tok;
      grant();
      for (int i = 0; i < 9; i++) begin
         if (i == 8) begin
            write_char(VEC[i][20], VEC[i][19:12], 150, got);
            check_eq("R8 ninth not acked", got, 0);
            grant();
         end
         write_char(VEC[i][20], VEC[i][19:12], 150, got);
         check_eq("R8 acked", got, 1);
      end
      cycles(60);
      check_eq("R6 token count", n_tok - base, 9);
      for (int i = 0; i < 9; i++)
         check_eq("R6 token kind/value", tok_k[base+i] * 256 + tok_v[base+i],
                  int'(VEC[i][11:8]) * 256 + int'(VEC[i][7:0]));

      // R7 time code
      base = n_tok;
      ctrl_in = 2'b10; time_in = 6'h2B; tick_in = 1'b1;
      cycles(1);
      tick_in = 1'b0;
      cycles(80);
      check_eq("R7 time token count", n_tok - base, 1);
      check_eq("R7 time value", tok_k[base] * 256 + tok_v[base], K_TIME * 256 + 8'hAB);

      // R9 flow tokens from room
      base = n_tok;
      fct_en = 1'b1; rx_room = 6'd16;
      cycles(100);
      check_eq("R9 two FCTs for room 16", count_kind(base, K_FCT), 2);
      rx_taken = 1'b1;
      cycles(8);
      rx_taken = 1'b0;
      cycles(60);
      check_eq("R9 one FCT after 8 taken", count_kind(base, K_FCT), 3);
      cycles(100);
      check_eq("R9 no extra FCT", count_kind(base, K_FCT), 3);

      // R10 priority: time, FCT, host
      base = n_tok;
      ctrl_in = 2'b00; time_in = 6'h07; tick_in = 1'b1;
      cycles(1);
      tick_in = 1'b0; rx_room = 6'd24;
      write_char(1'b0, 8'h11, 200, got);
      cycles(60);
      check_eq("R10 host acked", got, 1);
      check_eq("R10 token count", n_tok - base, 3);
      check_eq("R10 first time", tok_k[base] * 256 + tok_v[base], K_TIME * 256 + 8'h07);
      check_eq("R10 second FCT", tok_k[base+1], K_FCT);
      check_eq("R10 third data", tok_k[base+2] * 256 + tok_v[base+2], K_DATA * 256 + 8'h11);
      check_eq("R3 period div=1", per_bad, 0);

      // R12 disable
      disable_link();
      cycles(6);
      @(negedge clk);
      check_eq("R12 ds_d quiet", ds_d, 0);
      check_eq("R12 ds_s quiet", ds_s, 0);
      a0 = chg_cnt;
      cycles(40);
      check_eq("R12 lines still", chg_cnt - a0, 0);
      enable_link();
      base = n_tok;
      write_char(1'b0, 8'h99, 100, got);
      check_eq("R12 credit cleared", got, 0);
      check_eq("R12 promise cleared (3 FCTs for room 24)", count_kind(base, K_FCT), 3);
      fct_en = 1'b0;

      // R11 credit overflow
      e0 = err_cnt;
      for (int i = 0; i < 7; i++) grant();
      cycles(3);
      check_eq("R11 no error up to 56", err_cnt - e0, 0);
      grant();
      cycles(3);
      check_eq("R11 one error pulse", err_cnt - e0, 1);
      a0 = ack_cnt;
      for (int i = 0; i < 56; i++) begin
         write_char(1'b0, 8'(i), 100, got);
      end
      check_eq("R11 56 chars after overflow", ack_cnt - a0, 56);
      write_char(1'b0, 8'hEE, 100, got);
      check_eq("R11 credit held at 56", got, 0);

      // R3 other rate
      disable_link();
      cycles(20);
      div = 8'd3;
      cycles(10);
      a0 = null_cnt;
      enable_link();
      cycles(20);
      have_last = 0; arm = 1;
      cycles(300);
      check_eq("R3 period div=3", per_bad, 0);
      check_eq("R4 first char NULL div=3", first_kind, K_NULL);
      check(null_cnt - a0 >= 5, "R4 NULLs div=3", null_cnt - a0, 5);

      // final line-level checks
      check_eq("R2 one line per bit", enc_bad, 0);
      check_eq("R5 parity chain", par_bad, 0);
      check_eq("R6 no bad escape", count_kind(0, K_BAD), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule